// File: doc/BRIEF.md
# Endpoint Memory Window Hit Decoder

This block sits on the receive side of a PCIe endpoint and decides which of its memory windows an incoming request address falls into. Each window has a power-of-two size fixed when the block is built. From that size the block derives an address mask whose low log2(size) bits are clear and whose upper bits are set. Software places each window by writing a base value over a small configuration port. The block stores the base already trimmed by the mask.

For every request the block ANDs the address with each window's mask and compares the result with the stored base. One clock later it reports a one-hot hit vector, the encoded index of the winning window, a valid flag, and the byte offset inside that window. When two windows match, the lower index wins. A read on the configuration port returns the stored base with the attribute bits of a 32-bit, non-prefetchable memory window. Writing all ones and reading back therefore yields the mask, which is how software sizes each window.

Top module: `bar_hit_decoder`

## Requirements
- R1: For a window of 2^k bytes, writing 0xFFFF_FFFF and reading it back returns a value with the low k bits zero and the rest one (0xFFFF_0000 for 64 KB, 0xFFFF_FF80 for 128 bytes).
- R2: A written value is ANDed with the window's mask before it is stored. Writing 0x0000_02FF to a 256-byte window reads back 0x0000_0200. A window that is not written keeps its value.
- R3: Read data bits [3:0] are always 0000: bit 0 = 0 marks memory space, bits [2:1] = 00 mark a 32-bit window, and bit 3 = 0 marks non-prefetchable.
- R4: A window is hit when (address AND mask) equals its stored base. With a 256-byte window at 0x0000_0200, address 0x0000_0224 hits and address 0x0000_1024 misses.
- R5: Two adjacent 64 KB windows at 0x7000_0000 (index 0) and 0x7001_0000 (index 1) send 0x7001_xxxx only to index 1 and 0x7000_xxxx only to index 0.
- R6: When several windows match, only the lowest index is reported. hit_vec is zero or one-hot, and its set bit is at hit_idx.
- R7: hit_offset equals the address AND NOT the winning window's mask. On a miss, hit_offset, hit_idx and hit_vec are all zero.
- R8: While mem_en is low, no hit is reported in the following cycle.
- R9: After reset every stored base reads as zero and all hit outputs are zero.
- R10: Hit outputs are registered and appear in the cycle after req_valid is sampled. With req_valid low, the next cycle reports no hit. A base write in the same cycle as a request takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base write strobe |
| cfg_idx | input | IDX_W (2) | Window selected for write and read |
| cfg_wdata | input | ADDR_W (32) | Base write value |
| cfg_rdata | output | ADDR_W (32) | Stored base of the selected window, with attribute bits |
| mem_en | input | 1 | Global memory decode enable |
| req_valid | input | 1 | Request address valid |
| req_addr | input | ADDR_W (32) | Request address |
| hit_valid | output | 1 | Registered: a window was hit |
| hit_vec | output | NUM_BARS (4) | Registered one-hot hit vector |
| hit_idx | output | IDX_W (2) | Registered index of the winning window |
| hit_offset | output | ADDR_W (32) | Registered offset inside the winning window |

## Verification
The four hit outputs are due exactly one clock after the request inputs are sampled. cfg_rdata is combinational on the stored base, so a write shows up right after the edge that stores it. The bench drives inputs on the falling edge. At that moment its behavioural model computes the expected hit from the base values it holds before the coming rising edge, and only then applies any write to those values. At the next falling edge it compares all outputs, including the read-back of the window selected at that point. The model is therefore compared on every clock, and a write issued together with a request is checked against the old base.

// File: rtl/bar_dec_pkg.sv
package bar_dec_pkg;
   // attribute field returned in the low bits of every base read
   localparam int unsigned ATTR_W = 4;
   localparam logic        ATTR_IO_SPACE = 1'b0;        // memory space
   localparam logic [1:0]  ATTR_DECODE_TYPE = 2'b00;    // 32-bit decoder
   localparam logic        ATTR_PREFETCH = 1'b0;        // not prefetchable
   localparam logic [ATTR_W-1:0] ATTR_MEM32_NP =
      {ATTR_PREFETCH, ATTR_DECODE_TYPE, ATTR_IO_SPACE};

   function automatic int unsigned idx_width(int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/bar_window.sv
module bar_window
   import bar_dec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned SIZE_LOG2 = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] addr,
   output logic              match,
   output logic [ADDR_W-1:0] offset,
   output logic [ADDR_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << SIZE_LOG2;

   if (SIZE_LOG2 < ATTR_W || SIZE_LOG2 >= ADDR_W) begin : g_bad_size
      $error("bar_window: SIZE_LOG2 out of range");
   end

   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     base_q <= '0;
      else if (wr_en) base_q <= wr_data & MASK;
   end

   always_comb begin
      match   = ((addr & MASK) == base_q);
      offset  = addr & ~MASK;
      rd_data = base_q | {{(ADDR_W-ATTR_W){1'b0}}, ATTR_MEM32_NP};
   end

   AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data)) else $error("window base changed without write"); // R2
   AST_READ_ATTR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[ATTR_W-1:0] == 4'b0000) else $error("attribute bits wrong"); // R3
endmodule

// File: rtl/bar_hit_prio.sv
module bar_hit_prio #(
   parameter int unsigned NUM_BARS = 4,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IDX_W    = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           req_ok,
   input  logic [NUM_BARS-1:0]            match_vec,
   input  logic [NUM_BARS-1:0][ADDR_W-1:0] offset_vec,
   output logic                           hit_valid,
   output logic [NUM_BARS-1:0]            hit_vec,
   output logic [IDX_W-1:0]               hit_idx,
   output logic [ADDR_W-1:0]              hit_offset
);
   if ((1 << IDX_W) < NUM_BARS) begin : g_bad_idx
      $error("bar_hit_prio: IDX_W too narrow");
   end

   logic [NUM_BARS-1:0] sel;
   logic [IDX_W-1:0]    sel_idx;
   logic [ADDR_W-1:0]   sel_off;

   // walk from the top down so the lowest matching index is the last written
   always_comb begin
      sel     = '0;
      sel_idx = '0;
      sel_off = '0;
      for (int i = NUM_BARS - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            sel     = '0;
            sel[i]  = 1'b1;
            sel_idx = IDX_W'(i);
            sel_off = offset_vec[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !req_ok) begin
         hit_valid  <= 1'b0;
         hit_vec    <= '0;
         hit_idx    <= '0;
         hit_offset <= '0;
      end else begin
         hit_valid  <= |match_vec;
         hit_vec    <= sel;
         hit_idx    <= sel_idx;
         hit_offset <= sel_off;
      end
   end

   AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)) else $error("hit vector not one-hot"); // R6
   AST_IDX_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> hit_vec[hit_idx]) else $error("index disagrees with vector"); // R6
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_valid |-> (hit_vec == '0 && hit_offset == '0 && hit_idx == '0))
      else $error("miss outputs not zero"); // R7
   AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ok && match_vec[0]) |=> (hit_valid && hit_idx == '0))
      else $error("index 0 match not reported"); // R6
endmodule

// File: rtl/bar_hit_decoder.sv
module bar_hit_decoder
   import bar_dec_pkg::*;
#(
   parameter int unsigned NUM_BARS = 4,
   parameter int unsigned ADDR_W   = 32,
   // 8 bits per window: log2 of its size in bytes, window 0 in the low byte
   parameter logic [NUM_BARS*8-1:0] BAR_LOG2 = {8'd7, 8'd8, 8'd16, 8'd16},
   localparam int unsigned IDX_W = idx_width(NUM_BARS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [IDX_W-1:0]    cfg_idx,
   input  logic [ADDR_W-1:0]   cfg_wdata,
   output logic [ADDR_W-1:0]   cfg_rdata,
   input  logic                mem_en,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_addr,
   output logic                hit_valid,
   output logic [NUM_BARS-1:0] hit_vec,
   output logic [IDX_W-1:0]    hit_idx,
   output logic [ADDR_W-1:0]   hit_offset
);
   if (NUM_BARS < 1) begin : g_bad_count
      $error("bar_hit_decoder: NUM_BARS must be at least 1");
   end
   if (ADDR_W != 32) begin : g_bad_width
      $error("bar_hit_decoder: only 32-bit windows are supported");
   end

   logic [NUM_BARS-1:0]             match_vec;
   logic [NUM_BARS-1:0][ADDR_W-1:0] offset_vec;
   logic [NUM_BARS-1:0][ADDR_W-1:0] rd_vec;

   for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
      localparam int unsigned LG = int'(BAR_LOG2[g*8 +: 8]);
      bar_window #(
         .ADDR_W   (ADDR_W),
         .SIZE_LOG2(LG)
      ) i_win (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (cfg_we && (cfg_idx == IDX_W'(g))),
         .wr_data(cfg_wdata),
         .addr   (req_addr),
         .match  (match_vec[g]),
         .offset (offset_vec[g]),
         .rd_data(rd_vec[g])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int i = 0; i < NUM_BARS; i++)
         if (cfg_idx == IDX_W'(i)) cfg_rdata = rd_vec[i];
   end

   bar_hit_prio #(
      .NUM_BARS(NUM_BARS),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W)
   ) i_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_ok    (req_valid && mem_en),
      .match_vec (match_vec),
      .offset_vec(offset_vec),
      .hit_valid (hit_valid),
      .hit_vec   (hit_vec),
      .hit_idx   (hit_idx),
      .hit_offset(hit_offset)
   );

   AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_en |=> !hit_valid) else $error("hit while decode disabled"); // R8
   AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !hit_valid) else $error("hit without request"); // R10
endmodule

// File: tb/test_bar_hit_decoder.sv
module test_bar_hit_decoder;
   localparam int NB = 4;
   localparam int LG [NB] = '{16, 16, 8, 7};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_en = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        hit_valid;
   logic [3:0]  hit_vec;
   logic [1:0]  hit_idx;
   logic [31:0] hit_offset;

   always #2.5 clk = ~clk;

   bar_hit_decoder i_bar_hit_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_en(mem_en),
      .req_valid(req_valid), .req_addr(req_addr), .hit_valid(hit_valid),
      .hit_vec(hit_vec), .hit_idx(hit_idx), .hit_offset(hit_offset)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] mbase [NB];
   logic        e_valid;
   logic [3:0]  e_vec;
   logic [1:0]  e_idx;
   logic [31:0] e_off;

   function automatic logic [31:0] msk(int k);
      return 32'hFFFF_FFFF << k;
   endfunction

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: model the edge from current inputs, then compare at the next falling edge
   task automatic cycle(string tag);
      e_valid = 1'b0; e_vec = '0; e_idx = '0; e_off = '0;
      if (req_valid && mem_en) begin
         for (int i = 0; i < NB; i++) begin
            if (!e_valid && ((req_addr & msk(LG[i])) == mbase[i])) begin
               e_valid = 1'b1;
               e_vec[i] = 1'b1;
               e_idx = 2'(i);
               e_off = req_addr & ~msk(LG[i]);
            end
         end
      end
      if (cfg_we) mbase[cfg_idx] = cfg_wdata & msk(LG[cfg_idx]);
      @(posedge clk);
      @(negedge clk);
      cmp(tag, "hit_valid", 32'(hit_valid), 32'(e_valid));
      cmp(tag, "hit_vec", 32'(hit_vec), 32'(e_vec));
      cmp(tag, "hit_idx", 32'(hit_idx), 32'(e_idx));
      cmp(tag, "hit_offset", hit_offset, e_off);
      cmp(tag, "cfg_rdata", cfg_rdata, mbase[cfg_idx]);
   endtask

   task automatic wr(int idx, logic [31:0] v, string tag);
      cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = v;
      cycle(tag);
      cfg_we = 1'b0;
   endtask

   task automatic req(logic [31:0] a, string tag);
      req_valid = 1'b1; req_addr = a;
      cycle(tag);
      req_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < NB; i++) mbase[i] = '0;
      repeat (3) @(negedge clk);
      // R9: reset state
      cmp("R9", "hit_valid", 32'(hit_valid), 0);
      cmp("R9", "hit_vec", 32'(hit_vec), 0);
      cmp("R9", "hit_offset", hit_offset, 0);
      for (int i = 0; i < NB; i++) begin
         cfg_idx = 2'(i); #1;
         cmp("R9", "cfg_rdata", cfg_rdata, 0);
      end
      rst_n = 1'b1;
      mem_en = 1'b1;
      // R1: sizing reads
      wr(0, 32'hFFFF_FFFF, "R1");
      cmp("R1", "64KB mask", cfg_rdata, 32'hFFFF_0000);
      wr(3, 32'hFFFF_FFFF, "R1");
      cmp("R1", "128B mask", cfg_rdata, 32'hFFFF_FF80);
      // R2 / R3: aligned store, attribute bits zero
      wr(2, 32'h0000_02FF, "R2");
      cmp("R2", "aligned", cfg_rdata, 32'h0000_0200);
      cmp("R3", "attr bits", {28'h0, cfg_rdata[3:0]}, 32'h0);
      cfg_idx = 2'd3; cycle("R2");
      cmp("R2", "untouched", cfg_rdata, 32'hFFFF_FF80);
      wr(0, 32'h7000_0000, "R5");
      wr(1, 32'h7001_0000, "R5");
      wr(3, 32'h1000_0000, "R2");
      // R4
      req(32'h0000_0224, "R4");
      cmp("R4", "0x224 hits win2", 32'(hit_idx), 2);
      req(32'h0000_1024, "R4");
      cmp("R4", "0x1024 misses", 32'(hit_valid), 0);
      // R5: adjacent windows
      req(32'h7001_1234, "R5");
      cmp("R5", "upper window", 32'(hit_vec), 32'b0010);
      req(32'h7000_ABCD, "R5");
      cmp("R5", "lower window", 32'(hit_vec), 32'b0001);
      // R7: offset in small window
      req(32'h1000_007F, "R7");
      cmp("R7", "offset", hit_offset, 32'h7F);
      // R8: decode disabled
      mem_en = 1'b0;
      req(32'h7000_0010, "R8");
      cmp("R8", "disabled", 32'(hit_valid), 0);
      mem_en = 1'b1;
      // R10: back-to-back, idle, write together with request
      req_valid = 1'b1; req_addr = 32'h7001_0004; cycle("R10");
      req_addr = 32'h0000_0230; cycle("R10");
      req_valid = 1'b0; cycle("R10");
      cmp("R10", "idle", 32'(hit_valid), 0);
      req_valid = 1'b1; req_addr = 32'h0000_0210;
      cfg_we = 1'b1; cfg_idx = 2'd2; cfg_wdata = 32'h0000_0400;
      cycle("R10");
      cmp("R10", "old base used", 32'(hit_idx), 2);
      cfg_we = 1'b0; req_valid = 1'b0;
      // R6: overlapping windows, lowest index wins
      wr(2, 32'h7000_0100, "R6");
      req(32'h7000_0110, "R6");
      cmp("R6", "lowest wins", 32'(hit_vec), 32'b0001);
      wr(3, 32'h7000_0100, "R6");
      req(32'h7000_0105, "R6");
      cmp("R6", "offset from winner", hit_offset, 32'h0105);
      // mixed traffic
      for (int n = 0; n < 200; n++) begin
         logic [31:0] a;
         a = $urandom;
         case (n % 4)
            0: a = 32'h7000_0000 | (a & 32'h0001_FFFF);
            1: a = 32'h7000_0100 | (a & 32'hFF);
            2: a = 32'h1000_0000 | (a & 32'h1FF);
            default: ;
         endcase
         mem_en = (n % 7) != 0;
         req_valid = (n % 5) != 0;
         req_addr = a;
         cfg_idx = 2'(n % 4);
         cycle("R7");
      end
      req_valid = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #50000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule